// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, once per incoming frame, whether the frame is kept. A receive front end presents the frame's 48-bit destination, its length in bytes and the two error flags from the CRC checker, all qualified by a single-cycle valid strobe. The filter compares the destination against a programmed station address, looks group addresses up in a 64-bin hash array, recognises the all-ones broadcast address, and then applies the length and error policies. The result arrives one clock later as an accept bit and an address-type bit.

The same lookup also serves as a remote control channel. When remote transmitter control is enabled, an error-free group frame that hashes to the second-highest bin turns the transmitter off, and one that hashes to the highest bin turns it back on. The transmitter-enable state is held inside the block and is driven out as a level.

Destination and station address bytes are packed with the first byte on the wire in bits 7:0, the second in bits 15:8, and so on. Bin k of the hash array is bit k of the hash input.

Top module: `rx_dest_filter`

## Requirements
- R1: A result is reported exactly one clock after each `frm_valid` strobe: `res_valid` is high for that single cycle and low in all others, and `res_accept` is never high while `res_valid` is low. After reset `res_valid` and `res_accept` are 0 and `tx_enable` is 1.
- R2: A unicast destination (bit 0 of the first byte is 0) is accepted when it equals `my_addr` and rejected when it differs, provided promiscuous mode is off.
- R3: With `cfg_promisc` set, every unicast destination is accepted, whatever `my_addr` holds.
- R4: The broadcast destination (all 48 bits 1) is accepted only when `cfg_bcast` is set; the hash array and `cfg_mcast` play no part in that decision.
- R5: A group destination other than broadcast is accepted only when `cfg_mcast` is set and `mc_hash[idx]` is 1, where idx is bits 31..26 of a CRC-32 register (polynomial 0x04C11DB7, preset to all ones, no final inversion, shifted left) after the 48 destination bits are fed in, bit 0 of the first byte first and least significant bit first within each byte.
- R6: A frame shorter than 64 bytes is rejected unless `cfg_runt_ok` is set; a frame of exactly 64 bytes is not short.
- R7: A frame with `frm_crc_bad` or `frm_align_bad` set is rejected unless `cfg_keep_bad` is set.
- R8: `res_group` reports the address type of the frame: 0 for a unicast destination, 1 for a group or broadcast destination.
- R9: With `cfg_remote_tx` set, a non-broadcast group frame whose index (as in R5) is 62 clears `tx_enable` and one whose index is 63 sets it, in the same cycle that its result is reported; with `cfg_remote_tx` clear such frames leave `tx_enable` unchanged, and `tx_enable` never changes in a cycle without a result.
- R10: A frame with either error flag set never changes `tx_enable`, even when its index is 62 or 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe: frame fields below are valid |
| frm_dest | input | 48 | Destination address, first byte in bits 7:0 |
| frm_len | input | 16 | Frame length in bytes |
| frm_crc_bad | input | 1 | Frame failed the CRC check |
| frm_align_bad | input | 1 | Frame did not end on a byte boundary |
| my_addr | input | 48 | Station address, same byte packing as the destination |
| mc_hash | input | 64 | Group hash array, bin k in bit k |
| cfg_bcast | input | 1 | Accept broadcast |
| cfg_mcast | input | 1 | Accept group addresses that hit the hash array |
| cfg_promisc | input | 1 | Accept every unicast destination |
| cfg_runt_ok | input | 1 | Keep frames shorter than the minimum length |
| cfg_keep_bad | input | 1 | Keep frames with CRC or alignment errors |
| cfg_remote_tx | input | 1 | Let hash bins 62 and 63 switch the transmitter |
| res_valid | output | 1 | Result strobe, one cycle after `frm_valid` |
| res_accept | output | 1 | Frame is kept |
| res_group | output | 1 | 0 unicast destination, 1 group or broadcast |
| tx_enable | output | 1 | Transmitter enable state |

## Verification
Every result of this block (accept, address type, and the transmitter-enable update) lands on the rising edge that follows the strobe, so all three are due in the same cycle, one clock after the frame is presented. The bench drives each frame on a falling edge, drops the strobe on the next falling edge and reads all outputs at that instant, half a period after the register has loaded. One falling edge later it checks that the strobe has gone away again, and the transmitter tests read `tx_enable` at the same point, so a command that took effect late or early shows up as a wrong level.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   // receive policy bits, gathered from the individual configuration pins
   typedef struct packed {
      logic bcast;
      logic mcast;
      logic promisc;
      logic runt_ok;
      logic keep_bad;
      logic remote_tx;
   } rxf_cfg_t;

   // left-shifting CRC-32 generator polynomial
   localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

endpackage

// File: rtl/rxf_addr_class.sv
module rxf_addr_class #(
   parameter int ADDR_BYTES = 6,
   localparam int ADDR_W    = 8 * ADDR_BYTES
) (
   input  logic [ADDR_W-1:0] dest,
   input  logic [ADDR_W-1:0] station,
   output logic              is_group,
   output logic              is_bcast,
   output logic              station_hit
);

   logic [ADDR_BYTES-1:0] byte_eq;
   logic [ADDR_BYTES-1:0] byte_ones;

   // one comparator per address byte, reduced below
   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
      assign byte_eq[b]   = (dest[8*b +: 8] == station[8*b +: 8]);
      assign byte_ones[b] = &dest[8*b +: 8];
   end

   assign is_group    = dest[0];
   assign is_bcast    = &byte_ones;
   assign station_hit = &byte_eq;

endmodule

// File: rtl/rxf_hash_bin.sv
module rxf_hash_bin
   import rxf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS  = 6,
   localparam int ADDR_W    = 8 * ADDR_BYTES,
   localparam int HASH_BINS = 1 << HASH_BITS
) (
   input  logic [ADDR_W-1:0]    dest,
   input  logic [HASH_BINS-1:0] table_bits,
   output logic [HASH_BITS-1:0] bin_idx,
   output logic                 bin_set
);

   logic [31:0] crc;

   // serial CRC unrolled over the destination bits, wire order
   always_comb begin
      logic fb;
      crc = '1;
      for (int i = 0; i < ADDR_W; i++) begin
         fb  = crc[31] ^ dest[i];
         crc = {crc[30:0], 1'b0};
         if (fb) crc = crc ^ CRC_POLY;
      end
   end

   assign bin_idx = crc[31 -: HASH_BITS];
   assign bin_set = table_bits[bin_idx];

endmodule

// File: rtl/rxf_policy.sv
module rxf_policy
   import rxf_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int MIN_LEN   = 64,
   parameter int HASH_BITS = 6
) (
   input  rxf_cfg_t             cfg,
   input  logic [LEN_W-1:0]     len,
   input  logic                 crc_bad,
   input  logic                 align_bad,
   input  logic                 is_group,
   input  logic                 is_bcast,
   input  logic                 station_hit,
   input  logic [HASH_BITS-1:0] bin_idx,
   input  logic                 bin_set,
   output logic                 accept,
   output logic                 tx_off_cmd,
   output logic                 tx_on_cmd
);

   localparam int HASH_BINS = 1 << HASH_BITS;
   localparam logic [HASH_BITS-1:0] BIN_TX_OFF = HASH_BITS'(HASH_BINS - 2);
   localparam logic [HASH_BITS-1:0] BIN_TX_ON  = HASH_BITS'(HASH_BINS - 1);
   localparam logic [LEN_W-1:0]     LEN_MIN    = LEN_W'(MIN_LEN);

   logic bad, short_frm, addr_ok, group_only, remote_ok;

   assign bad        = crc_bad | align_bad;
   assign short_frm  = (len < LEN_MIN);
   assign group_only = is_group & ~is_bcast;

   always_comb begin
      if (is_bcast)      addr_ok = cfg.bcast;
      else if (is_group) addr_ok = cfg.mcast & bin_set;
      else               addr_ok = cfg.promisc | station_hit;
   end

   assign accept = addr_ok
                 & ~(bad & ~cfg.keep_bad)
                 & ~(short_frm & ~cfg.runt_ok);

   assign remote_ok  = cfg.remote_tx & group_only & ~bad;
   assign tx_off_cmd = remote_ok & (bin_idx == BIN_TX_OFF);
   assign tx_on_cmd  = remote_ok & (bin_idx == BIN_TX_ON);

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
   import rxf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS  = 6,
   parameter int LEN_W      = 16,
   parameter int MIN_LEN    = 64,
   localparam int ADDR_W    = 8 * ADDR_BYTES,
   localparam int HASH_BINS = 1 << HASH_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frm_valid,
   input  logic [ADDR_W-1:0]    frm_dest,
   input  logic [LEN_W-1:0]     frm_len,
   input  logic                 frm_crc_bad,
   input  logic                 frm_align_bad,
   input  logic [ADDR_W-1:0]    my_addr,
   input  logic [HASH_BINS-1:0] mc_hash,
   input  logic                 cfg_bcast,
   input  logic                 cfg_mcast,
   input  logic                 cfg_promisc,
   input  logic                 cfg_runt_ok,
   input  logic                 cfg_keep_bad,
   input  logic                 cfg_remote_tx,
   output logic                 res_valid,
   output logic                 res_accept,
   output logic                 res_group,
   output logic                 tx_enable
);

   // elaboration-time parameter checks
   if (ADDR_BYTES < 1) begin : g_bad_addr
      $error("rx_dest_filter: ADDR_BYTES must be at least 1");
   end
   if (HASH_BITS < 2 || HASH_BITS > 8) begin : g_bad_hash
      $error("rx_dest_filter: HASH_BITS must lie in 2..8");
   end
   if (MIN_LEN < 1 || MIN_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("rx_dest_filter: MIN_LEN must fit in LEN_W bits");
   end

   rxf_cfg_t             cfg;
   logic                 is_group, is_bcast, station_hit;
   logic [HASH_BITS-1:0] bin_idx;
   logic                 bin_set;
   logic                 accept_d, tx_off_cmd, tx_on_cmd;

   assign cfg = '{bcast:     cfg_bcast,
                  mcast:     cfg_mcast,
                  promisc:   cfg_promisc,
                  runt_ok:   cfg_runt_ok,
                  keep_bad:  cfg_keep_bad,
                  remote_tx: cfg_remote_tx};

   rxf_addr_class #(.ADDR_BYTES(ADDR_BYTES)) u_class (
      .dest        (frm_dest),
      .station     (my_addr),
      .is_group    (is_group),
      .is_bcast    (is_bcast),
      .station_hit (station_hit)
   );

   rxf_hash_bin #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_hash (
      .dest       (frm_dest),
      .table_bits (mc_hash),
      .bin_idx    (bin_idx),
      .bin_set    (bin_set)
   );

   rxf_policy #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .HASH_BITS(HASH_BITS)) u_policy (
      .cfg         (cfg),
      .len         (frm_len),
      .crc_bad     (frm_crc_bad),
      .align_bad   (frm_align_bad),
      .is_group    (is_group),
      .is_bcast    (is_bcast),
      .station_hit (station_hit),
      .bin_idx     (bin_idx),
      .bin_set     (bin_set),
      .accept      (accept_d),
      .tx_off_cmd  (tx_off_cmd),
      .tx_on_cmd   (tx_on_cmd)
   );

   // single result register stage; transmitter state updates alongside
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_group  <= 1'b0;
         tx_enable  <= 1'b1;
      end else begin
         res_valid  <= frm_valid;
         res_accept <= frm_valid & accept_d;
         if (frm_valid) begin
            res_group <= is_group;
            if (tx_off_cmd)     tx_enable <= 1'b0;
            else if (tx_on_cmd) tx_enable <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk #(
   parameter int ADDR_W  = 48,
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_valid,
   input logic [ADDR_W-1:0] frm_dest,
   input logic [LEN_W-1:0]  frm_len,
   input logic              frm_crc_bad,
   input logic              frm_align_bad,
   input logic [ADDR_W-1:0] my_addr,
   input logic              cfg_bcast,
   input logic              cfg_promisc,
   input logic              cfg_runt_ok,
   input logic              cfg_keep_bad,
   input logic              res_valid,
   input logic              res_accept,
   input logic              res_group,
   input logic              tx_enable
);

   localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);

   a_r1_result_next: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> res_valid);

   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> !res_valid);

   a_r1_accept_in_result: assert property (@(posedge clk) disable iff (!rst_n)
      res_accept |-> res_valid);

   a_r2_own_station: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && frm_dest == my_addr && !frm_dest[0]
      && !frm_crc_bad && !frm_align_bad && frm_len >= LEN_MIN
      |=> res_accept);

   a_r3_promisc_unicast: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && cfg_promisc && !frm_dest[0]
      && !frm_crc_bad && !frm_align_bad && frm_len >= LEN_MIN
      |=> res_accept);

   a_r4_bcast_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && (&frm_dest) && !cfg_bcast |=> !res_accept);

   a_r6_runt_drop: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && frm_len < LEN_MIN && !cfg_runt_ok |=> !res_accept);

   a_r7_error_drop: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && (frm_crc_bad || frm_align_bad) && !cfg_keep_bad
      |=> !res_accept);

   a_r8_addr_type: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> res_group == $past(frm_dest[0]));

   a_r9_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> $stable(tx_enable));

   a_r10_tx_bad_frame: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && (frm_crc_bad || frm_align_bad) |=> $stable(tx_enable));

endmodule

bind rx_dest_filter rx_dest_filter_chk #(
   .ADDR_W  (ADDR_W),
   .LEN_W   (LEN_W),
   .MIN_LEN (MIN_LEN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .frm_valid     (frm_valid),
   .frm_dest      (frm_dest),
   .frm_len       (frm_len),
   .frm_crc_bad   (frm_crc_bad),
   .frm_align_bad (frm_align_bad),
   .my_addr       (my_addr),
   .cfg_bcast     (cfg_bcast),
   .cfg_promisc   (cfg_promisc),
   .cfg_runt_ok   (cfg_runt_ok),
   .cfg_keep_bad  (cfg_keep_bad),
   .res_valid     (res_valid),
   .res_accept    (res_accept),
   .res_group     (res_group),
   .tx_enable     (tx_enable)
);

// File: tb/tb_rx_dest_filter.sv
`timescale 1ns/1ps
module tb_rx_dest_filter;

   localparam logic [47:0] STA   = 48'h1A2B_3C4D_5E60;  // first byte 0x60: unicast
   localparam logic [47:0] OTHER = 48'h1A2B_3C4D_5F60;
   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] MCA   = 48'h1122_3344_5501;  // first byte 0x01: group
   localparam int NV = 16;

   // {dest, len, cfg{bcast,mcast,promisc,runt_ok,keep_bad,remote_tx},
   //  crc_bad, align_bad, hash_all_ones, exp_accept, exp_group}
   localparam logic [74:0] VEC [NV] = '{
      {STA,   16'd100, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 own station
      {OTHER, 16'd100, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 foreign
      {OTHER, 16'd100, 6'b001000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 promiscuous
      {BCAST, 16'd100, 6'b100000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 on
      {BCAST, 16'd100, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 off
      {MCA,   16'd100, 6'b010000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R5 hit
      {MCA,   16'd100, 6'b000000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R5 mcast off
      {MCA,   16'd100, 6'b010000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R5 empty table
      {STA,   16'd63,  6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 runt
      {STA,   16'd63,  6'b000100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 runt kept
      {STA,   16'd64,  6'b000000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 boundary
      {STA,   16'd100, 6'b000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R7 crc
      {STA,   16'd100, 6'b000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R7 alignment
      {STA,   16'd100, 6'b000010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R7 kept
      {BCAST, 16'd40,  6'b100000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R6 short bcast
      {BCAST, 16'd100, 6'b010000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}   // R4 not via hash
   };
   localparam int VREQ [NV] = '{2,2,3,4,4,5,5,5,6,6,6,7,7,7,6,4};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_valid = 1'b0;
   logic [47:0] frm_dest = '0;
   logic [15:0] frm_len = '0;
   logic        frm_crc_bad = 1'b0, frm_align_bad = 1'b0;
   logic [47:0] my_addr = STA;
   logic [63:0] mc_hash = '0;
   logic        cfg_bcast = 0, cfg_mcast = 0, cfg_promisc = 0;
   logic        cfg_runt_ok = 0, cfg_keep_bad = 0, cfg_remote_tx = 0;
   logic        res_valid, res_accept, res_group, tx_enable;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;  // 125 MHz

   rx_dest_filter dut (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_dest(frm_dest),
      .frm_len(frm_len), .frm_crc_bad(frm_crc_bad), .frm_align_bad(frm_align_bad),
      .my_addr(my_addr), .mc_hash(mc_hash), .cfg_bcast(cfg_bcast),
      .cfg_mcast(cfg_mcast), .cfg_promisc(cfg_promisc), .cfg_runt_ok(cfg_runt_ok),
      .cfg_keep_bad(cfg_keep_bad), .cfg_remote_tx(cfg_remote_tx),
      .res_valid(res_valid), .res_accept(res_accept), .res_group(res_group),
      .tx_enable(tx_enable)
   );

   task automatic chk(input logic ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // reflected CRC-32; the bit-reversed register equals the left-shift form
   function automatic logic [5:0] ref_bin(input logic [47:0] a);
      logic [31:0] r;
      logic fb;
      r = '1;
      for (int i = 0; i < 48; i++) begin
         fb = r[0] ^ a[i];
         r  = r >> 1;
         if (fb) r = r ^ 32'hEDB8_8320;
      end
      return {r[0], r[1], r[2], r[3], r[4], r[5]};
   endfunction

   task automatic set_cfg(input logic [5:0] c);
      {cfg_bcast, cfg_mcast, cfg_promisc, cfg_runt_ok, cfg_keep_bad, cfg_remote_tx} = c;
   endtask

   // present one frame; outputs are read half a period after the result edge
   task automatic send(input logic [47:0] d, input logic [15:0] l,
                       input logic cb, input logic ab);
      @(negedge clk);
      frm_dest = d; frm_len = l; frm_crc_bad = cb; frm_align_bad = ab;
      frm_valid = 1'b1;
      @(negedge clk);
      frm_valid = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [47:0] a62, a63;
      logic        f62, f63;
      logic [5:0]  bi;

      repeat (3) @(negedge clk);
      chk(res_valid === 1'b0,  "R1 reset valid",  64'(res_valid),  0);
      chk(res_accept === 1'b0, "R1 reset accept", 64'(res_accept), 0);
      chk(tx_enable === 1'b1,  "R1 reset tx",     64'(tx_enable),  1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         set_cfg(VEC[i][10:5]);
         mc_hash = VEC[i][2] ? '1 : '0;
         send(VEC[i][74:27], VEC[i][26:11], VEC[i][4], VEC[i][3]);
         chk(res_valid === 1'b1, $sformatf("R1 vector %0d valid", i), 64'(res_valid), 1);
         chk(res_accept === VEC[i][1], $sformatf("R%0d vector %0d accept", VREQ[i], i),
             64'(res_accept), 64'(VEC[i][1]));
         chk(res_group === VEC[i][0], $sformatf("R8 vector %0d group", i),
             64'(res_group), 64'(VEC[i][0]));
         @(negedge clk);
         chk(res_valid === 1'b0, $sformatf("R1 vector %0d single pulse", i), 64'(res_valid), 0);
      end

      // R5: only the computed bin decides
      set_cfg(6'b010000);
      bi = ref_bin(MCA);
      mc_hash = 64'd1 << bi;
      send(MCA, 16'd100, 0, 0);
      chk(res_accept === 1'b1, "R5 own bin set", 64'(res_accept), 1);
      mc_hash = ~(64'd1 << bi);
      send(MCA, 16'd100, 0, 0);
      chk(res_accept === 1'b0, "R5 all bins but own", 64'(res_accept), 0);

      // find group addresses landing in bins 62 and 63
      f62 = 0; f63 = 0; a62 = '0; a63 = '0;
      for (int k = 0; k < 4096; k++) begin
         logic [47:0] a;
         a = {k[11:0], 36'h0_0000_0001};
         if (!f62 && ref_bin(a) == 6'd62) begin a62 = a; f62 = 1; end
         if (!f63 && ref_bin(a) == 6'd63) begin a63 = a; f63 = 1; end
      end
      chk(f62 && f63, "R9 command addresses found", {f62, f63}, 2'b11);

      mc_hash = '0;
      set_cfg(6'b000000);
      send(a62, 16'd100, 0, 0);
      chk(tx_enable === 1'b1, "R9 control off ignores bin 62", 64'(tx_enable), 1);
      set_cfg(6'b000001);
      send(a62, 16'd100, 1, 0);
      chk(tx_enable === 1'b1, "R10 errored bin 62", 64'(tx_enable), 1);
      send(a62, 16'd100, 0, 1);
      chk(tx_enable === 1'b1, "R10 misaligned bin 62", 64'(tx_enable), 1);
      send(a62, 16'd100, 0, 0);
      chk(tx_enable === 1'b0, "R9 bin 62 disables", 64'(tx_enable), 0);
      send(STA, 16'd100, 0, 0);
      chk(tx_enable === 1'b0, "R9 unicast keeps state", 64'(tx_enable), 0);
      send(a63, 16'd100, 1, 0);
      chk(tx_enable === 1'b0, "R10 errored bin 63", 64'(tx_enable), 0);
      send(a63, 16'd100, 0, 0);
      chk(tx_enable === 1'b1, "R9 bin 63 enables", 64'(tx_enable), 1);

      // reset returns the transmitter to enabled
      send(a62, 16'd100, 0, 0);
      chk(tx_enable === 1'b0, "R9 disabled again", 64'(tx_enable), 0);
      rst_n = 1'b0;
      @(negedge clk);
      chk(tx_enable === 1'b1, "R1 reset restores tx", 64'(tx_enable), 1);
      rst_n = 1'b1;
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule